// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a program sequencer and takes over the branching and counting work of software loops. A block loop is opened by a strobe that arrives with the fetch of the loop instruction, together with an iteration count and the address of the body's last instruction. From then on, the controller compares every fetch address against that last address. It steers the next fetch back to the first body instruction in the same cycle, so a pass through the loop costs only the cycles of its body.

A second strobe starts a single-instruction repeat. The instruction that follows it is fetched again and again until its count runs out. The repeat may sit anywhere inside an active block loop, including on the body's last instruction. Block loops nest through a small hardware stack of loop records. While an interrupt is being serviced, the controller freezes completely. When the handler returns, the sequencer re-fetches the interrupted address and every loop continues with the count it had.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, `redirect_valid`, `fetch_hold`, `loop_active` and `stack_err` are all 0, and `loop_active` is 1 exactly while at least one block loop record is held.
- R2: A block loop with count N >= 1 whose loop instruction is at address P and whose last body address is E runs the body P+1..E exactly N times. It takes 1 + N*(E-P) fetch cycles from the loop instruction to the first fetch of E+1: at each fetch of E with iterations left, `redirect_valid` is 1 and `redirect_pc` is P+1 in that same cycle.
- R3: On the final iteration, the fetch of E raises no redirect, the record is popped, and the next fetch is E+1. `loop_active` is 0 once the last record is gone.
- R4: A block loop with count 0 raises `redirect_valid` with `redirect_pc` = E+1 in the cycle of the loop instruction and never fetches the body.
- R5: A repeat with count N that is issued at address Q makes the instruction at Q+1 be fetched N consecutive times, with `fetch_hold` = 1 on all but the last of them. A count of 0 or 1 fetches it once.
- R6: A repeat inside a block loop works in every iteration. When the repeated instruction is the body's last one, the end-of-loop test is skipped while `fetch_hold` is 1, so the loop keeps its iteration count.
- R7: Block loops nest up to DEPTH levels. Only the innermost record is tested, and when it pops the enclosing loop carries on with its own count.
- R8: A loop instruction with a non-zero count that arrives while the stack holds DEPTH records sets `stack_err`, which stays 1 until reset. The new loop is discarded and the loops already held run unchanged.
- R9: The controller is frozen from the cycle `irq_take` is 1 up to and including the cycle `irq_return` is 1. While frozen, `redirect_valid` and `fetch_hold` are 0, loop and repeat strobes are ignored, and no count changes. After the return, both loop kinds finish with the iteration totals they would have had without the interrupt.
- R10: `redirect_valid` and `fetch_hold` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | 16 | Address being fetched this cycle |
| do_start | input | 1 | The fetched instruction opens a block loop |
| do_count | input | 16 | Iteration count of the block loop |
| do_end | input | 16 | Address of the last body instruction |
| rep_start | input | 1 | The fetched instruction starts a single-instruction repeat |
| rep_count | input | 16 | Number of times the next instruction runs |
| irq_take | input | 1 | The sequencer discards this fetch and enters an interrupt handler |
| irq_return | input | 1 | The last cycle of the interrupt handler |
| redirect_valid | output | 1 | The next fetch address is `redirect_pc` |
| redirect_pc | output | 16 | Override for the next fetch address |
| fetch_hold | output | 1 | The next fetch address is the current one again |
| loop_active | output | 1 | At least one block loop is open |
| stack_err | output | 1 | Sticky flag for an attempt to nest beyond DEPTH |

## Verification
The bench builds the block with its defaults: 16-bit addresses and counts and a two-entry loop stack. With a stack of two, three nested loop instructions reach overflow. The bench acts as the sequencer itself and runs short programs at low addresses. It sweeps loop counts 0 to 5 over body lengths 1 to 3, repeat counts 0 to 3 on inner and on last body instructions, and inner counts 0 to 2 under outer counts 1 to 3. It also places an interrupt at every cycle of a loop and of a repeat. Fetch counts per address and total cycle counts are predicted as products of the programmed counts.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    localparam int LOOP_AW = 16;
    localparam int LOOP_CW = 16;

    typedef logic [LOOP_AW-1:0] addr_t;
    typedef logic [LOOP_CW-1:0] cnt_t;

    typedef struct packed {
        addr_t start_pc;
        addr_t end_pc;
        cnt_t  count;
    } loop_entry_t;

    function automatic addr_t addr_inc(input addr_t a);
        return a + addr_t'(1);
    endfunction

    function automatic logic more_than_one(input cnt_t c);
        return c > cnt_t'(1);
    endfunction

endpackage

// File: rtl/hwloop_stack.sv
module hwloop_stack
    import hwloop_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  loop_entry_t push_entry,
    input  logic        pop,
    input  logic        dec,
    output loop_entry_t top_entry,
    output logic        empty,
    output logic        full
);
    localparam int SPW = $clog2(DEPTH + 1);

    logic [SPW-1:0] sp_q;
    loop_entry_t    slot_vec [DEPTH];

    assign empty = (sp_q == '0);
    assign full  = (sp_q == SPW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (push && !full) begin
            sp_q <= sp_q + SPW'(1);
        end else if (pop && !empty) begin
            sp_q <= sp_q - SPW'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        loop_entry_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (push && !full && sp_q == SPW'(g)) begin
                q <= push_entry;
            end else if (dec && !push && !pop && sp_q == SPW'(g + 1)) begin
                q.count <= q.count - cnt_t'(1);
            end
        end
        assign slot_vec[g] = q;
    end

    always_comb begin
        top_entry = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_q == SPW'(i + 1)) top_entry = slot_vec[i];
        end
    end

    // R7
    sp_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sp_q <= SPW'(DEPTH));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !push && !pop && !empty) |=> top_entry.count == $past(top_entry.count) - cnt_t'(1));

endmodule

// File: rtl/hwloop_rep_unit.sv
module hwloop_rep_unit
    import hwloop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t load_cnt,
    input  logic freeze,
    output logic hold
);
    logic active_q;
    cnt_t left_q;

    assign hold = active_q && !freeze;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            left_q   <= '0;
        end else if (load) begin
            active_q <= more_than_one(load_cnt);
            left_q   <= load_cnt;
        end else if (hold) begin
            left_q   <= left_q - cnt_t'(1);
            active_q <= left_q > cnt_t'(2);
        end
    end

    // R5
    rep_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> left_q == $past(left_q) - cnt_t'(1));

    // R9
    rep_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && !load) |=> $stable(left_q));

endmodule

// File: rtl/hwloop_do_eval.sv
module hwloop_do_eval
    import hwloop_pkg::*;
(
    input  addr_t       fetch_pc,
    input  logic        do_start,
    input  cnt_t        do_count,
    input  addr_t       do_end,
    input  logic        freeze,
    input  logic        hold,
    input  logic        stk_empty,
    input  loop_entry_t stk_top,
    output logic        push,
    output loop_entry_t push_entry,
    output logic        pop,
    output logic        dec,
    output logic        redirect,
    output addr_t       redirect_pc
);
    logic live, zero_skip, at_end, again;

    always_comb begin
        live      = !freeze;
        zero_skip = live && do_start && (do_count == '0);
        push      = live && do_start && (do_count != '0);
        at_end    = live && !do_start && !hold && !stk_empty && (fetch_pc == stk_top.end_pc);
        again     = more_than_one(stk_top.count);
        dec       = at_end && again;
        pop       = at_end && !again;

        push_entry.start_pc = addr_inc(fetch_pc);
        push_entry.end_pc   = do_end;
        push_entry.count    = do_count;

        redirect    = zero_skip || dec;
        redirect_pc = zero_skip ? addr_inc(do_end) : stk_top.start_pc;
        if (!redirect) redirect_pc = '0;
    end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LOOP_AW-1:0] fetch_pc,
    input  logic               do_start,
    input  logic [LOOP_CW-1:0] do_count,
    input  logic [LOOP_AW-1:0] do_end,
    input  logic               rep_start,
    input  logic [LOOP_CW-1:0] rep_count,
    input  logic               irq_take,
    input  logic               irq_return,
    output logic               redirect_valid,
    output logic [LOOP_AW-1:0] redirect_pc,
    output logic               fetch_hold,
    output logic               loop_active,
    output logic               stack_err
);
    logic        in_isr_q, freeze;
    logic        push, pop, dec, stk_empty, stk_full;
    loop_entry_t push_entry, stk_top;

    assign freeze = irq_take || in_isr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_isr_q <= 1'b0;
        end else if (irq_take) begin
            in_isr_q <= 1'b1;
        end else if (irq_return) begin
            in_isr_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stack_err <= 1'b0;
        end else if (push && stk_full) begin
            stack_err <= 1'b1;
        end
    end

    hwloop_rep_unit u_rep (
        .clk      (clk),
        .rst      (rst),
        .load     (rep_start && !freeze),
        .load_cnt (rep_count),
        .freeze   (freeze),
        .hold     (fetch_hold)
    );

    hwloop_do_eval u_eval (
        .fetch_pc    (fetch_pc),
        .do_start    (do_start),
        .do_count    (do_count),
        .do_end      (do_end),
        .freeze      (freeze),
        .hold        (fetch_hold),
        .stk_empty   (stk_empty),
        .stk_top     (stk_top),
        .push        (push),
        .push_entry  (push_entry),
        .pop         (pop),
        .dec         (dec),
        .redirect    (redirect_valid),
        .redirect_pc (redirect_pc)
    );

    hwloop_stack #(.DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .dec        (dec),
        .top_entry  (stk_top),
        .empty      (stk_empty),
        .full       (stk_full)
    );

    assign loop_active = !stk_empty;

    // R10
    hold_redirect_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_hold && redirect_valid));

    // R9
    isr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        in_isr_q |-> (!redirect_valid && !fetch_hold));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stack_err |=> stack_err);

    // R3
    pop_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> !$past(redirect_valid));

endmodule

// File: tb/hwloop_ctrl_tb.sv
module hwloop_ctrl_tb;
    import hwloop_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ISR_BASE   = 100;
    localparam int ISR_LEN    = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [LOOP_AW-1:0] fetch_pc = '0;
    logic               do_start = 1'b0;
    logic [LOOP_CW-1:0] do_count = '0;
    logic [LOOP_AW-1:0] do_end = '0;
    logic               rep_start = 1'b0;
    logic [LOOP_CW-1:0] rep_count = '0;
    logic               irq_take = 1'b0;
    logic               irq_return = 1'b0;
    logic               redirect_valid;
    logic [LOOP_AW-1:0] redirect_pc;
    logic               fetch_hold;
    logic               loop_active;
    logic               stack_err;

    hwloop_ctrl u_dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .do_start(do_start), .do_count(do_count), .do_end(do_end),
        .rep_start(rep_start), .rep_count(rep_count),
        .irq_take(irq_take), .irq_return(irq_return),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .fetch_hold(fetch_hold), .loop_active(loop_active), .stack_err(stack_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int hits [128];
    int kind [128];
    int pcnt [128];
    int pend [128];
    int body_cyc;
    int isr_bad;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 128; i++) begin
            kind[i] = 0; pcnt[i] = 0; pend[i] = 0;
        end
    endtask

    // kind 1: block loop, kind 2: repeat
    task automatic run(input int start, input int stop, input int irq_at);
        int pc, nxt, cyc, saved, k;
        bit isr, take;
        pc = start; cyc = 0; isr = 0; k = 0; saved = 0;
        body_cyc = 0; isr_bad = 0;
        for (int i = 0; i < 128; i++) hits[i] = 0;
        forever begin
            @(negedge clk);
            if (!isr && pc == stop) break;
            fetch_pc = LOOP_AW'(pc);
            do_start = 0; rep_start = 0; irq_take = 0; irq_return = 0;
            take = !isr && (cyc == irq_at);
            if (take) begin
                irq_take = 1;
                saved = pc;
            end else if (isr) begin
                irq_return = (k == ISR_LEN - 1);
            end else begin
                hits[pc[6:0]]++;
                body_cyc++;
                if (kind[pc[6:0]] == 1) begin
                    do_start = 1;
                    do_count = LOOP_CW'(pcnt[pc[6:0]]);
                    do_end   = LOOP_AW'(pend[pc[6:0]]);
                end else if (kind[pc[6:0]] == 2) begin
                    rep_start = 1;
                    rep_count = LOOP_CW'(pcnt[pc[6:0]]);
                end
            end
            #1;
            if ((take || isr) && (redirect_valid || fetch_hold)) isr_bad++;
            if (take) begin
                nxt = ISR_BASE; isr = 1; k = 0;
            end else if (isr) begin
                if (k == ISR_LEN - 1) begin
                    nxt = saved; isr = 0;
                end else begin
                    nxt = pc + 1; k++;
                end
            end else if (fetch_hold) begin
                nxt = pc;
            end else if (redirect_valid) begin
                nxt = int'(redirect_pc);
            end else begin
                nxt = pc + 1;
            end
            cyc++;
            if (cyc > 4000) begin
                chk(0, "R2 run bound", cyc, 4000);
                break;
            end
            @(posedge clk);
            pc = nxt;
        end
        do_start = 0; rep_start = 0; irq_take = 0; irq_return = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int rr;
        clear_prog();
        do_reset();
        #1;
        // R1 reset state
        chk(redirect_valid == 0, "R1 redirect", redirect_valid, 0);
        chk(fetch_hold == 0, "R1 hold", fetch_hold, 0);
        chk(loop_active == 0, "R1 loop_active", loop_active, 0);
        chk(stack_err == 0, "R1 stack_err", stack_err, 0);

        // R2 R3 R4: counts 0..5 over body lengths 1..3
        for (int n = 0; n <= 5; n++) begin
            for (int len = 1; len <= 3; len++) begin
                clear_prog();
                kind[10] = 1; pcnt[10] = n; pend[10] = 10 + len;
                run(10, 11 + len, -1);
                if (n == 0) begin
                    chk(hits[11] == 0, "R4 body skipped", hits[11], 0);
                    chk(body_cyc == 1, "R4 cycles", body_cyc, 1);
                end else begin
                    chk(hits[11] == n, "R2 first body fetches", hits[11], n);
                    chk(hits[10 + len] == n, "R2 last body fetches", hits[10 + len], n);
                    chk(body_cyc == 1 + n * len, "R2 zero overhead cycles", body_cyc, 1 + n * len);
                end
                chk(loop_active == 0, "R3 loop_active after exit", loop_active, 0);
            end
        end

        // R5 plain repeat
        for (int r = 0; r <= 4; r++) begin
            clear_prog();
            kind[10] = 2; pcnt[10] = r;
            rr = (r == 0) ? 1 : r;
            run(10, 12, -1);
            chk(hits[11] == rr, "R5 repeat fetches", hits[11], rr);
        end

        // R6 repeat inside a loop, inner and last body instruction
        for (int c = 1; c <= 3; c++) begin
            for (int r = 0; r <= 3; r++) begin
                rr = (r == 0) ? 1 : r;
                clear_prog();
                kind[10] = 1; pcnt[10] = c; pend[10] = 13;
                kind[11] = 2; pcnt[11] = r;
                run(10, 14, -1);
                chk(hits[12] == c * rr, "R6 inner repeat", hits[12], c * rr);
                chk(hits[13] == c, "R6 loop end count", hits[13], c);
                clear_prog();
                kind[10] = 1; pcnt[10] = c; pend[10] = 13;
                kind[12] = 2; pcnt[12] = r;
                run(10, 14, -1);
                chk(hits[13] == c * rr, "R6 repeat on last", hits[13], c * rr);
                chk(hits[11] == c, "R6 iterations kept", hits[11], c);
            end
        end

        // R7 nested block loops
        for (int c1 = 1; c1 <= 3; c1++) begin
            for (int c2 = 0; c2 <= 2; c2++) begin
                clear_prog();
                kind[10] = 1; pcnt[10] = c1; pend[10] = 15;
                kind[11] = 1; pcnt[11] = c2; pend[11] = 13;
                run(10, 16, -1);
                chk(hits[12] == c1 * c2, "R7 inner body", hits[12], c1 * c2);
                chk(hits[15] == c1, "R7 outer end", hits[15], c1);
                chk(stack_err == 0, "R7 no overflow", stack_err, 0);
            end
        end

        // R9 interrupt at every cycle of a block loop
        for (int at = 0; at <= 9; at++) begin
            clear_prog();
            kind[10] = 1; pcnt[10] = 4; pend[10] = 12;
            run(10, 13, at);
            chk(hits[11] == 4 && hits[12] == 4, "R9 loop across interrupt", hits[12], 4);
            chk(isr_bad == 0, "R9 quiet while frozen", isr_bad, 0);
        end
        // R9 interrupt at every cycle of a repeat
        for (int at = 0; at <= 5; at++) begin
            clear_prog();
            kind[10] = 2; pcnt[10] = 4;
            run(10, 12, at);
            chk(hits[11] == 4, "R9 repeat across interrupt", hits[11], 4);
            chk(isr_bad == 0, "R9 quiet while frozen", isr_bad, 0);
        end

        // R8 overflow on third nested loop
        clear_prog();
        kind[10] = 1; pcnt[10] = 2; pend[10] = 20;
        kind[11] = 1; pcnt[11] = 2; pend[11] = 18;
        kind[12] = 1; pcnt[12] = 3; pend[12] = 14;
        run(10, 21, -1);
        chk(stack_err == 1, "R8 stack_err set", stack_err, 1);
        chk(hits[13] == 4, "R8 discarded loop not run", hits[13], 4);
        chk(hits[20] == 2, "R8 outer loops intact", hits[20], 2);
        repeat (3) @(negedge clk);
        chk(stack_err == 1, "R8 sticky", stack_err, 1);

        finish_up();
    end

endmodule